// File: doc/BRIEF.md
# Broadcast-Addressed Register Bank

This block holds three identical sets of control registers. Each set has a 3-bit mode register and an 8-bit rate register. Software reaches them over a simple bus that is one byte wide, byte-addressed and 32 bits in address. Each set has its own address window. A fourth window acts as a broadcast alias. One write there loads the addressed register in all three sets on the same clock edge, so software can program every set in one bus cycle. Every register value is exported on output ports, so downstream logic can see it without a bus read.

Each bus access is one cycle long: a write strobe or a read strobe together with an address. A write takes effect on the edge that samples it. Read data is registered and appears on the cycle after the read strobe. An access to an address that maps to no register returns zero and raises an error flag for one cycle.

Top module: `bcr_regbank`

## Requirements
- R1: While the reset input is low, all six registers, the read data and the error flag are zero, and reset takes effect without waiting for a clock edge.
- R2: Address bits [25:24] select the window: 0, 1 and 2 select set 0, 1 and 2, and 3 selects broadcast. Within a window, offset 0x0 is the mode register and offset 0x4 is the rate register.
- R3: A write to a set's own window updates only that register in that set, and the new value is visible on the outputs after the edge that samples the write strobe.
- R4: A write to the broadcast window (base 0x0300_0000) loads the written value into the addressed register of all three sets on the same edge.
- R5: A mode write, whether per-set or broadcast, leaves every rate register unchanged, and a rate write leaves every mode register unchanged.
- R6: A mode write stores only write-data bits [2:0], and a read of any mode register returns zero in bits [7:3].
- R7: Read data is registered: the value addressed by a read strobe appears on the read data output in the cycle after the strobe and holds until the next read.
- R8: A read from the broadcast window returns the value held by set 0.
- R9: An address with any of bits [31:26] set, or with an offset other than 0x0 or 0x4, is unmapped. A read there returns 0, a write there changes no register, and either access raises the error flag for exactly one cycle.
- R10: In a cycle with no write strobe, no register changes, and in a cycle with no strobe at all, the error flag is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| bus_addr | input | 32 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_err | output | 1 | One-cycle flag for an access to an unmapped address |
| mode_q | output | 9 | Mode registers of all sets, 3 bits each, set 0 in the low bits |
| rate_q | output | 24 | Rate registers of all sets, 8 bits each, set 0 in the low bits |

## Verification
Every cycle, the assertions check four things. A broadcast write lands in all three sets together. A mode write leaves all rate registers alone, and a rate write leaves all mode registers alone. Nothing changes without a write strobe. Unmapped reads return zero with the error flag set, and broadcast reads mirror set 0. Other behaviour is shown only by the bench's scenarios. These are the exact per-window addressing and the fact that a per-set write leaves its siblings alone. They also include the sweep of every offset in every window for hits and misses, the one-cycle length of the error pulse, and the asynchronous clearing by a mid-run reset.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  localparam int unsigned BCR_INST_W = 2;

  typedef enum logic {
    REG_MODE = 1'b0,
    REG_RATE = 1'b1
  } bcr_reg_e;

  typedef struct packed {
    logic                  hit;
    logic                  bcast;
    logic [BCR_INST_W-1:0] inst;
    bcr_reg_e              rsel;
  } bcr_dec_t;

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
  import bcr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned INST_LSB = 24,
  parameter int unsigned N_INST   = 3,
  parameter int unsigned MODE_OFS = 0,
  parameter int unsigned RATE_OFS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output bcr_dec_t          dec
);

  localparam int unsigned         UPPER_LSB  = INST_LSB + BCR_INST_W;
  localparam logic [BCR_INST_W-1:0] BCAST_CODE = '1;
  localparam logic [INST_LSB-1:0] MODE_OFS_L = MODE_OFS[INST_LSB-1:0];
  localparam logic [INST_LSB-1:0] RATE_OFS_L = RATE_OFS[INST_LSB-1:0];

  logic [BCR_INST_W-1:0] sel;
  logic [INST_LSB-1:0]   ofs;
  logic                  upper_clear;
  logic                  is_bcast;
  logic                  inst_valid;
  logic                  ofs_mode;
  logic                  ofs_rate;

  always_comb begin
    sel         = addr[INST_LSB +: BCR_INST_W];
    ofs         = addr[INST_LSB-1:0];
    upper_clear = (addr[ADDR_W-1:UPPER_LSB] == '0);
    is_bcast    = (sel == BCAST_CODE);
    inst_valid  = is_bcast || (32'(sel) < N_INST);
    ofs_mode    = (ofs == MODE_OFS_L);
    ofs_rate    = (ofs == RATE_OFS_L);

    dec.hit   = upper_clear && inst_valid && (ofs_mode || ofs_rate);
    dec.bcast = is_bcast;
    dec.inst  = is_bcast ? '0 : sel;
    dec.rsel  = ofs_rate ? REG_RATE : REG_MODE;
  end

endmodule

// File: rtl/bcr_inst.sv
module bcr_inst #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MODE_W = 3,
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              rate_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic [RATE_W-1:0] rate_q
);

  logic [MODE_W-1:0] mode_d;
  logic [RATE_W-1:0] rate_d;

  always_comb begin
    mode_d = mode_q;
    rate_d = rate_q;
    if (mode_we) mode_d = wdata[MODE_W-1:0];
    if (rate_we) rate_d = wdata[RATE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rate_q <= '0;
    end else begin
      if (mode_we) mode_q <= mode_d;
      if (rate_we) rate_q <= rate_d;
    end
  end

endmodule

// File: rtl/bcr_rdport.sv
module bcr_rdport
  import bcr_pkg::*;
#(
  parameter int unsigned N_INST = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MODE_W = 3,
  parameter int unsigned RATE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd,
  input  logic                     acc,
  input  bcr_dec_t                 dec,
  input  logic [N_INST*MODE_W-1:0] mode_all,
  input  logic [N_INST*RATE_W-1:0] rate_all,
  output logic [DATA_W-1:0]        rdata,
  output logic                     err
);

  logic [MODE_W-1:0] mode_sel;
  logic [RATE_W-1:0] rate_sel;
  logic [DATA_W-1:0] value;
  logic [DATA_W-1:0] rdata_d;
  logic              err_d;

  always_comb begin
    mode_sel = '0;
    rate_sel = '0;
    for (int k = 0; k < N_INST; k++) begin
      if (32'(dec.inst) == k) begin
        mode_sel = mode_all[k*MODE_W +: MODE_W];
        rate_sel = rate_all[k*RATE_W +: RATE_W];
      end
    end
    if (dec.rsel == REG_RATE) value = {{(DATA_W-RATE_W){1'b0}}, rate_sel};
    else                      value = {{(DATA_W-MODE_W){1'b0}}, mode_sel};
    rdata_d = dec.hit ? value : '0;
    err_d   = acc && !dec.hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      if (rd) rdata <= rdata_d;
      err <= err_d;
    end
  end

endmodule

// File: rtl/bcr_regbank.sv
module bcr_regbank
  import bcr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned N_INST   = 3,
  parameter int unsigned MODE_W   = 3,
  parameter int unsigned RATE_W   = 8,
  parameter int unsigned INST_LSB = 24,
  parameter int unsigned MODE_OFS = 0,
  parameter int unsigned RATE_OFS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_err,
  output logic [N_INST*MODE_W-1:0] mode_q,
  output logic [N_INST*RATE_W-1:0] rate_q
);

  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  bcr_dec_t dec;

  bcr_decode #(
    .ADDR_W  (ADDR_W),
    .INST_LSB(INST_LSB),
    .N_INST  (N_INST),
    .MODE_OFS(MODE_OFS),
    .RATE_OFS(RATE_OFS)
  ) u_decode (
    .addr(bus_addr),
    .dec (dec)
  );

  logic [BCR_INST_W-1:0] wr_sel;
  assign wr_sel = bus_addr[INST_LSB +: BCR_INST_W];

  for (genvar g = 0; g < N_INST; g++) begin : g_inst
    logic targeted;
    logic mode_we;
    logic rate_we;

    always_comb begin
      targeted = bus_wr && dec.hit && (dec.bcast || (32'(wr_sel) == g));
      mode_we  = targeted && (dec.rsel == REG_MODE);
      rate_we  = targeted && (dec.rsel == REG_RATE);
    end

    bcr_inst #(
      .DATA_W(DATA_W),
      .MODE_W(MODE_W),
      .RATE_W(RATE_W)
    ) u_inst (
      .clk    (clk),
      .rst_n  (core_rst_n),
      .mode_we(mode_we),
      .rate_we(rate_we),
      .wdata  (bus_wdata),
      .mode_q (mode_q[g*MODE_W +: MODE_W]),
      .rate_q (rate_q[g*RATE_W +: RATE_W])
    );
  end

  bcr_rdport #(
    .N_INST(N_INST),
    .DATA_W(DATA_W),
    .MODE_W(MODE_W),
    .RATE_W(RATE_W)
  ) u_rdport (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .rd      (bus_rd),
    .acc     (bus_rd || bus_wr),
    .dec     (dec),
    .mode_all(mode_q),
    .rate_all(rate_q),
    .rdata   (bus_rdata),
    .err     (bus_err)
  );

endmodule

// File: rtl/bcr_chk.sv
module bcr_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned N_INST   = 3,
  parameter int unsigned MODE_W   = 3,
  parameter int unsigned RATE_W   = 8,
  parameter int unsigned INST_LSB = 24,
  parameter int unsigned MODE_OFS = 0,
  parameter int unsigned RATE_OFS = 4
) (
  input logic                     clk,
  input logic                     core_rst_n,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_wr,
  input logic                     bus_rd,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic                     bus_err,
  input logic [N_INST*MODE_W-1:0] mode_q,
  input logic [N_INST*RATE_W-1:0] rate_q
);

  localparam int unsigned     SEL_W   = 2;
  localparam logic [ADDR_W-1:0] BC_BASE = ADDR_W'(3) << INST_LSB;
  localparam logic [ADDR_W-1:0] BC_MODE = BC_BASE | ADDR_W'(MODE_OFS);
  localparam logic [ADDR_W-1:0] BC_RATE = BC_BASE | ADDR_W'(RATE_OFS);

  logic upper_set;
  logic mode_ofs_valid;
  assign upper_set      = (bus_addr[ADDR_W-1:INST_LSB+SEL_W] != '0);
  assign mode_ofs_valid = !upper_set && (bus_addr[INST_LSB-1:0] == INST_LSB'(MODE_OFS));

  for (genvar g = 0; g < N_INST; g++) begin : g_each
    // R4: broadcast mode write reaches every set
    p_bcast_mode_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
      (bus_wr && bus_addr == BC_MODE) |=>
        mode_q[g*MODE_W +: MODE_W] == $past(bus_wdata[MODE_W-1:0]));
    // R4: broadcast rate write reaches every set
    p_bcast_rate_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
      (bus_wr && bus_addr == BC_RATE) |=>
        rate_q[g*RATE_W +: RATE_W] == $past(bus_wdata[RATE_W-1:0]));
  end

  // R5: mode writes leave rates alone and rate writes leave modes alone
  p_mode_keeps_rate_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_wr && bus_addr == BC_MODE) |=> $stable(rate_q));
  p_rate_keeps_mode_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_wr && bus_addr == BC_RATE) |=> $stable(mode_q));

  // R6: mode read-back has zero upper bits
  p_mode_upper_zero_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_rd && mode_ofs_valid) |=> bus_rdata[DATA_W-1:MODE_W] == '0);

  // R8: broadcast mode read mirrors set 0
  p_bcast_read_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_rd && !bus_wr && bus_addr == BC_MODE) |=>
      bus_rdata == DATA_W'($past(mode_q[MODE_W-1:0])));

  // R9: unmapped read returns zero with the error flag
  p_unmapped_read_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_rd && upper_set) |=> (bus_err && bus_rdata == '0));

  // R10: no write strobe, no register change
  p_hold_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    !bus_wr |=> ($stable(mode_q) && $stable(rate_q)));
  // R10: error flag stays low after an idle cycle
  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(bus_wr || bus_rd) |=> !bus_err);

endmodule

bind bcr_regbank bcr_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .N_INST  (N_INST),
  .MODE_W  (MODE_W),
  .RATE_W  (RATE_W),
  .INST_LSB(INST_LSB),
  .MODE_OFS(MODE_OFS),
  .RATE_OFS(RATE_OFS)
) u_chk (
  .clk       (clk),
  .core_rst_n(core_rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .mode_q    (mode_q),
  .rate_q    (rate_q)
);

// File: tb/bcr_regbank_tb.sv
`timescale 1ns/1ps
module bcr_regbank_tb_top;

  logic        clk;
  logic        rst_n;
  logic [31:0] bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        bus_err;
  logic [8:0]  mode_q;
  logic [23:0] rate_q;

  int vectors;
  int miscompares;
  int cycles;
  bit done;

  logic [2:0] mode_m [3];
  logic [7:0] rate_m [3];

  bcr_regbank dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .bus_err  (bus_err),
    .mode_q   (mode_q),
    .rate_q   (rate_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        vectors++;
        miscompares++;
        $display("FAIL watchdog R10: act=%0d cycles exp=completion", cycles);
        report();
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(string req);
    for (int k = 0; k < 3; k++) begin
      chk(req, 32'(mode_q[k*3 +: 3]), 32'(mode_m[k]));
      chk(req, 32'(rate_q[k*8 +: 8]), 32'(rate_m[k]));
    end
  endtask

  task automatic bus_write(logic [31:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(logic [31:0] a, output logic [7:0] d, output logic e);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    d = bus_rdata;
    e = bus_err;
  endtask

  function automatic logic mapped(logic [31:0] a);
    return (a[31:26] == 6'd0) && (a[23:0] == 24'h0 || a[23:0] == 24'h4);
  endfunction

  function automatic logic [7:0] expect_read(logic [31:0] a);
    int w;
    w = (a[25:24] == 2'd3) ? 0 : int'(a[25:24]);
    if (!mapped(a)) return 8'h00;
    if (a[2]) return rate_m[w];
    return {5'b0, mode_m[w]};
  endfunction

  task automatic model_write(logic [31:0] a, logic [7:0] d);
    if (!mapped(a)) return;
    for (int k = 0; k < 3; k++) begin
      if (a[25:24] == 2'd3 || int'(a[25:24]) == k) begin
        if (a[2]) rate_m[k] = d;
        else      mode_m[k] = d[2:0];
      end
    end
  endtask

  task automatic readback_all(string req);
    logic [7:0] d;
    logic e;
    for (int w = 0; w < 4; w++) begin
      for (int r = 0; r < 2; r++) begin
        logic [31:0] a;
        a = (32'(w) << 24) | 32'(r * 4);
        bus_read(a, d, e);
        chk(req, 32'(d), 32'(expect_read(a)));
        chk(req, 32'(e), 32'd0);
      end
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < 3; k++) begin
      mode_m[k] = '0;
      rate_m[k] = '0;
    end
  endtask

  initial begin
    logic [7:0]  d;
    logic        e;
    logic [8:0]  m_snap;
    logic [23:0] r_snap;
    logic [7:0]  pats [6];
    logic [31:0] bad  [7];

    vectors = 0; miscompares = 0; done = 1'b0;
    pats = '{8'hA5, 8'h5A, 8'hFF, 8'h00, 8'h3C, 8'hC3};
    bad  = '{32'h0000_0001, 32'h0000_0008, 32'h0400_0000, 32'h0100_0100,
             32'h8000_0000, 32'h0300_0002, 32'h0201_0004};
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    clear_model();

    // R1: reset state
    repeat (3) @(negedge clk);
    chk_outputs("R1");
    chk("R1", 32'(bus_rdata), 32'd0);
    chk("R1", 32'(bus_err), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_outputs("R1");
    readback_all("R1");

    // R2 R3 R4 R5 R6 R7 R8: sweep of windows, registers and data patterns
    for (int w = 0; w < 4; w++) begin
      for (int r = 0; r < 2; r++) begin
        for (int p = 0; p < 6; p++) begin
          logic [31:0] a;
          logic [7:0]  dv;
          a  = (32'(w) << 24) | 32'(r * 4);
          dv = pats[p] ^ 8'(w * 16 + r * 3);
          bus_write(a, dv);
          model_write(a, dv);
          chk_outputs(w == 3 ? "R4" : "R3");
          chk_outputs("R5");
          readback_all((r == 0) ? "R6" : "R7");
          bus_read(32'h0300_0000, d, e);
          chk("R8", 32'(d), 32'({5'b0, mode_m[0]}));
        end
      end
    end

    // R7: read data holds until the next read
    bus_read(32'h0100_0004, d, e);
    repeat (3) @(negedge clk);
    chk("R7", 32'(bus_rdata), 32'(rate_m[1]));

    // R9: every offset in every window, reads
    for (int w = 0; w < 4; w++) begin
      for (int o = 0; o < 8; o++) begin
        logic [31:0] a;
        a = (32'(w) << 24) | 32'(o);
        bus_read(a, d, e);
        chk("R9", 32'(d), 32'(expect_read(a)));
        chk("R9", 32'(e), 32'(!mapped(a)));
        @(negedge clk);
        chk("R9", 32'(bus_err), 32'd0);
      end
    end

    // R9: unmapped reads and writes
    for (int i = 0; i < 7; i++) begin
      m_snap = mode_q; r_snap = rate_q;
      bus_write(bad[i], 8'h77);
      chk("R9", 32'(bus_err), 32'd1);
      chk("R9", 32'(mode_q), 32'(m_snap));
      chk("R9", 32'(rate_q), 32'(r_snap));
      @(negedge clk);
      chk("R9", 32'(bus_err), 32'd0);
      bus_read(bad[i], d, e);
      chk("R9", 32'(d), 32'd0);
      chk("R9", 32'(e), 32'd1);
    end

    // R10: idle cycles with data and address wiggling
    m_snap = mode_q; r_snap = rate_q;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bus_addr  = 32'(i % 2) << 24;
      bus_wdata = 8'(i * 37);
      @(negedge clk);
      chk("R10", 32'(mode_q), 32'(m_snap));
      chk("R10", 32'(rate_q), 32'(r_snap));
      chk("R10", 32'(bus_err), 32'd0);
    end

    // R3: per-set write leaves the other sets alone
    bus_write(32'h0300_0004, 8'h11);
    model_write(32'h0300_0004, 8'h11);
    bus_write(32'h0200_0004, 8'hEE);
    model_write(32'h0200_0004, 8'hEE);
    chk_outputs("R3");

    // R1: asynchronous reset mid-run
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    clear_model();
    chk_outputs("R1");
    chk("R1", 32'(bus_rdata), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    readback_all("R1");

    done = 1'b1;
    report();
  end

endmodule